// File: doc/BRIEF.md
# Shared-Pool Multi-Queue FIFO

This block holds up to sixteen independent first-in first-out queues inside one shared word memory and runs on a single clock. The pool is divided into fixed-size blocks, and each queue owns a whole number of them. A queue that owns no blocks is inactive. On a write, the incoming word goes to the queue named on the write side. On the read side, the head word of the queue named there is presented at once, in first-word-fall-through style. The write-side and read-side queue selects are independent of each other. One write and one read can both complete in the same cycle, even when they name the same queue.

Each stored word carries a 36-bit payload and two marks, start of packet and end of packet. Each queue keeps its own count of complete packets, and raises a packet-ready flag while that count is non-zero. Every queue also drives an almost-full flag and an almost-empty flag, each compared against that queue's own threshold. A configuration port sets a queue's block count and thresholds. A partial reset empties one queue, and takes effect only when both ports select that queue.

Top module: `mq_fifo`

## Requirements
- R1: After reset, each of the NQ queues owns POOL_BLKS/NQ blocks (default 1 block of 64 words), almost-full threshold 8 and almost-empty threshold 4. Every queue is empty, so rd_valid=0, wr_full=0, pae_vec is all ones, and paf_vec and prdy_vec are all zeros.
- R2: A write with wr_en=1 appends {wr_sop, wr_eop, wr_data} to queue wr_q. While queue rd_q holds data, rd_valid=1 and its oldest word appears on rd_sop, rd_eop and rd_data. A read with rd_en=1 and rd_valid=1 removes that word, and the queue's order is first in, first out.
- R3: A write and a read accepted in the same cycle both complete, whether they address the same queue or different queues.
- R4: wr_full=1 while queue wr_q holds as many words as its capacity (blocks × BLK_WORDS). A write in that state is ignored and the queue's contents do not change.
- R5: A read while rd_valid=0 is ignored and changes no queue.
- R6: With prst=1 and wr_q equal to rd_q, that queue is emptied at the clock edge, and no write or read takes effect in that cycle. With prst=1 and wr_q different from rd_q, prst has no effect.
- R7: prdy_vec[q]=1 while queue q holds at least one word marked end of packet. The count rises when such a word is accepted on a write and falls when such a word is read out.
- R8: paf_vec[q]=1 when count+af_threshold ≥ capacity. pae_vec[q]=1 when count ≤ ae_threshold.
- R9: A configuration write with cfg_we=1 sets queue cfg_q to own cfg_blks blocks, with thresholds cfg_af and cfg_ae. It is accepted only if the block total over all queues stays ≤ POOL_BLKS. An accepted write empties every queue, and no data write or read takes effect in that cycle. A rejected write changes nothing.
- R10: A queue with zero blocks is inactive: wr_full=1 when it is selected for writing, and rd_valid=0 when it is selected for reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master reset |
| wr_en | input | 1 | Write request |
| wr_q | input | QW | Queue selected for writing |
| wr_data | input | DW | Write payload |
| wr_sop | input | 1 | Start-of-packet mark for the written word |
| wr_eop | input | 1 | End-of-packet mark for the written word |
| wr_full | output | 1 | Queue wr_q is full |
| rd_en | input | 1 | Read request |
| rd_q | input | QW | Queue selected for reading |
| rd_data | output | DW | Head payload of queue rd_q |
| rd_sop | output | 1 | Start-of-packet mark of the head word |
| rd_eop | output | 1 | End-of-packet mark of the head word |
| rd_valid | output | 1 | Queue rd_q holds data |
| prst | input | 1 | Partial reset of the queue selected on both ports |
| cfg_we | input | 1 | Configuration write |
| cfg_q | input | QW | Queue being configured |
| cfg_blks | input | BW | Number of blocks for that queue |
| cfg_af | input | CW | Almost-full threshold |
| cfg_ae | input | CW | Almost-empty threshold |
| paf_vec | output | NQ | Almost-full flag of each queue |
| pae_vec | output | NQ | Almost-empty flag of each queue |
| prdy_vec | output | NQ | Packet-ready flag of each queue |

## Verification
The assertions check several rules on every cycle. No write is accepted into a full queue, and no read is accepted from an empty one. A write into the read-selected queue makes data visible on the next cycle. A partial reset or an accepted configuration write leaves the read-selected queue empty. Packet-ready and almost-empty stay consistent with the valid flag. Word ordering, payload integrity across wrap-around, exact capacities after reconfiguration, threshold arithmetic and the rejection of an oversized configuration can only be shown by the bench's scenarios, which compare against a per-queue reference model.

// File: rtl/mq_pkg.sv
package mq_pkg;

  typedef struct packed {
    logic sop;
    logic eop;
  } mark_t;

  function automatic int words_of(int blks, int blk_words);
    return blks * blk_words;
  endfunction

  function automatic logic near_full(int cnt, int cap, int thr);
    return (cnt + thr) >= cap;
  endfunction

  function automatic logic near_empty(int cnt, int thr);
    return cnt <= thr;
  endfunction

  function automatic int step_wrap(int ofs, int cap);
    return (ofs + 1 >= cap) ? 0 : ofs + 1;
  endfunction

endpackage

// File: rtl/mq_cfg.sv
module mq_cfg
  import mq_pkg::*;
#(
  parameter int NQ        = 16,
  parameter int QW        = 4,
  parameter int BW        = 5,
  parameter int CW        = 11,
  parameter int BLK_WORDS = 64,
  parameter int POOL_BLKS = 16,
  parameter int DEF_AF    = 8,
  parameter int DEF_AE    = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [QW-1:0]          cfg_q,
  input  logic [BW-1:0]          cfg_blks,
  input  logic [CW-1:0]          cfg_af,
  input  logic [CW-1:0]          cfg_ae,
  output logic                   cfg_acc,
  output logic [NQ-1:0][CW-1:0]  q_base,
  output logic [NQ-1:0][CW-1:0]  q_cap,
  output logic [NQ-1:0][CW-1:0]  q_af,
  output logic [NQ-1:0][CW-1:0]  q_ae
);
  logic [NQ-1:0][BW-1:0] blks;
  int total;

  always_comb begin
    int acc;
    acc   = 0;
    total = 0;
    for (int q = 0; q < NQ; q++) begin
      q_base[q] = CW'(acc);
      q_cap[q]  = CW'(words_of(int'(blks[q]), BLK_WORDS));
      acc       = acc + words_of(int'(blks[q]), BLK_WORDS);
      total     = total + int'(blks[q]);
    end
  end

  assign cfg_acc = cfg_we &&
                   (total - int'(blks[cfg_q]) + int'(cfg_blks) <= POOL_BLKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < NQ; q++) begin
        blks[q] <= BW'(POOL_BLKS / NQ);
        q_af[q] <= CW'(DEF_AF);
        q_ae[q] <= CW'(DEF_AE);
      end
    end else if (cfg_acc) begin
      blks[cfg_q] <= cfg_blks;
      q_af[cfg_q] <= cfg_af;
      q_ae[cfg_q] <= cfg_ae;
    end
  end
endmodule

// File: rtl/mq_qstate.sv
module mq_qstate
  import mq_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] cap,
  input  logic [CW-1:0] af_thr,
  input  logic [CW-1:0] ae_thr,
  input  logic          wr_go,
  input  logic          wr_eop,
  input  logic          rd_go,
  input  logic          rd_eop,
  output logic [CW-1:0] wofs,
  output logic [CW-1:0] rofs,
  output logic          full,
  output logic          empty,
  output logic          paf,
  output logic          pae,
  output logic          prdy
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] pkts;
  logic          pk_up, pk_dn;

  assign pk_up = wr_go && wr_eop;
  assign pk_dn = rd_go && rd_eop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; pkts <= '0; wofs <= '0; rofs <= '0;
    end else if (clr) begin
      cnt <= '0; pkts <= '0; wofs <= '0; rofs <= '0;
    end else begin
      if (wr_go) wofs <= CW'(step_wrap(int'(wofs), int'(cap)));
      if (rd_go) rofs <= CW'(step_wrap(int'(rofs), int'(cap)));
      case ({wr_go, rd_go})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      case ({pk_up, pk_dn})
        2'b10:   pkts <= pkts + 1'b1;
        2'b01:   pkts <= pkts - 1'b1;
        default: pkts <= pkts;
      endcase
    end
  end

  assign full  = (cnt == cap);
  assign empty = (cnt == '0);
  assign paf   = near_full(int'(cnt), int'(cap), int'(af_thr));
  assign pae   = near_empty(int'(cnt), int'(ae_thr));
  assign prdy  = (pkts != '0);
endmodule

// File: rtl/mq_mem.sv
module mq_mem #(
  parameter int WW    = 38,
  parameter int AW    = 10,
  parameter int DEPTH = 1024
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);
  logic [WW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/mq_fifo.sv
module mq_fifo
  import mq_pkg::*;
#(
  parameter int NQ        = 16,
  parameter int DW        = 36,
  parameter int BLK_WORDS = 64,
  parameter int POOL_BLKS = 16,
  parameter int DEF_AF    = 8,
  parameter int DEF_AE    = 4,
  localparam int QW       = $clog2(NQ),
  localparam int BW       = $clog2(POOL_BLKS + 1),
  localparam int POOL     = BLK_WORDS * POOL_BLKS,
  localparam int AW       = $clog2(POOL),
  localparam int CW       = AW + 1,
  localparam int WW       = DW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [QW-1:0] wr_q,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_sop,
  input  logic          wr_eop,
  output logic          wr_full,
  input  logic          rd_en,
  input  logic [QW-1:0] rd_q,
  output logic [DW-1:0] rd_data,
  output logic          rd_sop,
  output logic          rd_eop,
  output logic          rd_valid,
  input  logic          prst,
  input  logic          cfg_we,
  input  logic [QW-1:0] cfg_q,
  input  logic [BW-1:0] cfg_blks,
  input  logic [CW-1:0] cfg_af,
  input  logic [CW-1:0] cfg_ae,
  output logic [NQ-1:0] paf_vec,
  output logic [NQ-1:0] pae_vec,
  output logic [NQ-1:0] prdy_vec
);
  logic [NQ-1:0][CW-1:0] q_base, q_cap, q_af, q_ae, wofs, rofs;
  logic [NQ-1:0]         full_v, empty_v;
  logic                  cfg_acc, prst_hit, hold, wr_ok, rd_ok;
  logic [AW-1:0]         waddr, raddr;
  logic [WW-1:0]         head;
  mark_t                 in_mk, head_mk;

  mq_cfg #(
    .NQ(NQ), .QW(QW), .BW(BW), .CW(CW), .BLK_WORDS(BLK_WORDS),
    .POOL_BLKS(POOL_BLKS), .DEF_AF(DEF_AF), .DEF_AE(DEF_AE)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_q(cfg_q),
    .cfg_blks(cfg_blks), .cfg_af(cfg_af), .cfg_ae(cfg_ae),
    .cfg_acc(cfg_acc), .q_base(q_base), .q_cap(q_cap), .q_af(q_af), .q_ae(q_ae)
  );

  // Named events used by the bound checker.
  assign prst_hit = prst && (wr_q == rd_q);
  assign hold     = prst_hit || cfg_acc;
  assign wr_full  = full_v[wr_q];
  assign rd_valid = !empty_v[rd_q];
  assign wr_ok    = wr_en && !wr_full && !hold;
  assign rd_ok    = rd_en && rd_valid && !hold;

  assign in_mk   = '{sop: wr_sop, eop: wr_eop};
  assign head_mk = mark_t'(head[WW-1:DW]);
  assign rd_data = head[DW-1:0];
  assign rd_sop  = head_mk.sop;
  assign rd_eop  = head_mk.eop;

  assign waddr = AW'(q_base[wr_q] + wofs[wr_q]);
  assign raddr = AW'(q_base[rd_q] + rofs[rd_q]);

  mq_mem #(.WW(WW), .AW(AW), .DEPTH(POOL)) u_mem (
    .clk(clk), .we(wr_ok), .waddr(waddr), .wdata({in_mk, wr_data}),
    .raddr(raddr), .rdata(head)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic clr_q;
    assign clr_q = cfg_acc || (prst_hit && (rd_q == QW'(q)));
    mq_qstate #(.CW(CW)) u_qs (
      .clk(clk), .rst_n(rst_n), .clr(clr_q),
      .cap(q_cap[q]), .af_thr(q_af[q]), .ae_thr(q_ae[q]),
      .wr_go(wr_ok && (wr_q == QW'(q))), .wr_eop(wr_eop),
      .rd_go(rd_ok && (rd_q == QW'(q))), .rd_eop(head_mk.eop),
      .wofs(wofs[q]), .rofs(rofs[q]),
      .full(full_v[q]), .empty(empty_v[q]),
      .paf(paf_vec[q]), .pae(pae_vec[q]), .prdy(prdy_vec[q])
    );
  end
endmodule

// File: rtl/mq_fifo_chk.sv
module mq_fifo_chk #(
  parameter int NQ = 16,
  parameter int QW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_full,
  input logic          wr_ok,
  input logic [QW-1:0] wr_q,
  input logic          rd_valid,
  input logic          rd_ok,
  input logic [QW-1:0] rd_q,
  input logic          prst_hit,
  input logic          cfg_acc,
  input logic [NQ-1:0] pae_vec,
  input logic [NQ-1:0] prdy_vec
);
  a_r4_full_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_full |-> !wr_ok);

  a_r5_empty_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> !rd_ok);

  a_r3_write_shows_data: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && wr_q == rd_q) |=> (rd_valid || rd_q != $past(rd_q)));

  a_r6_prst_empties: assert property (@(posedge clk) disable iff (!rst_n)
    prst_hit |=> (!rd_valid || rd_q != $past(rd_q)));

  a_r9_cfg_empties: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_acc |=> !rd_valid);

  a_r7_ready_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    prdy_vec[rd_q] |-> rd_valid);

  a_r8_empty_is_low: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> pae_vec[rd_q]);
endmodule

bind mq_fifo mq_fifo_chk #(.NQ(NQ), .QW(QW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_full(wr_full), .wr_ok(wr_ok), .wr_q(wr_q),
  .rd_valid(rd_valid), .rd_ok(rd_ok), .rd_q(rd_q), .prst_hit(prst_hit),
  .cfg_acc(cfg_acc), .pae_vec(pae_vec), .prdy_vec(prdy_vec)
);

// File: tb/test_mq_fifo.sv
`timescale 1ns/1ps
module test_mq_fifo;
  localparam int NQ = 16, DW = 36, BLKW = 64, PB = 16;
  localparam int QW = 4, BW = 5, CW = 11, MB = 1024;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_sop = 0, wr_eop = 0, rd_en = 0, prst = 0, cfg_we = 0;
  logic [QW-1:0] wr_q = 0, rd_q = 0, cfg_q = 0;
  logic [DW-1:0] wr_data = 0;
  logic [BW-1:0] cfg_blks = 0;
  logic [CW-1:0] cfg_af = 0, cfg_ae = 0;
  logic wr_full, rd_sop, rd_eop, rd_valid;
  logic [DW-1:0] rd_data;
  logic [NQ-1:0] paf_vec, pae_vec, prdy_vec;

  always #5 clk = ~clk;

  mq_fifo i_mq_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_q(wr_q), .wr_data(wr_data),
    .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_full(wr_full), .rd_en(rd_en),
    .rd_q(rd_q), .rd_data(rd_data), .rd_sop(rd_sop), .rd_eop(rd_eop),
    .rd_valid(rd_valid), .prst(prst), .cfg_we(cfg_we), .cfg_q(cfg_q),
    .cfg_blks(cfg_blks), .cfg_af(cfg_af), .cfg_ae(cfg_ae),
    .paf_vec(paf_vec), .pae_vec(pae_vec), .prdy_vec(prdy_vec)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // Reference model
  logic [DW+1:0] m_buf [NQ][MB];
  int m_hd[NQ], m_cnt[NQ], m_cap[NQ], m_af[NQ], m_ae[NQ], m_pk[NQ], m_blk[NQ];

  function automatic logic exp_paf(int q);
    return (m_cnt[q] + m_af[q]) >= m_cap[q];
  endfunction
  function automatic logic exp_pae(int q);
    return m_cnt[q] <= m_ae[q];
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int q = 0; q < NQ; q++) begin
      m_hd[q] = 0; m_cnt[q] = 0; m_pk[q] = 0; m_blk[q] = PB / NQ;
      m_cap[q] = m_blk[q] * BLKW; m_af[q] = 8; m_ae[q] = 4;
    end
  endtask

  task automatic compare();
    logic [NQ-1:0] ef, ee, er;
    int rq, wq;
    rq = int'(rd_q); wq = int'(wr_q);
    chk(rd_valid == (m_cnt[rq] > 0), "R5 rd_valid", rd_valid, m_cnt[rq] > 0);
    if (rd_valid && m_cnt[rq] > 0)
      chk({rd_sop, rd_eop, rd_data} == m_buf[rq][m_hd[rq]], "R2 head word",
          {rd_sop, rd_eop, rd_data}, m_buf[rq][m_hd[rq]]);
    chk(wr_full == (m_cnt[wq] == m_cap[wq]), "R4 wr_full", wr_full,
        m_cnt[wq] == m_cap[wq]);
    for (int q = 0; q < NQ; q++) begin
      ef[q] = exp_paf(q); ee[q] = exp_pae(q); er[q] = m_pk[q] > 0;
    end
    chk(paf_vec == ef, "R8 paf_vec", paf_vec, ef);
    chk(pae_vec == ee, "R8 pae_vec", pae_vec, ee);
    chk(prdy_vec == er, "R7 prdy_vec", prdy_vec, er);
  endtask

  task automatic model_step();
    int wq, rq, tot;
    bit acc, hit, rok, wok;
    logic [DW+1:0] w;
    wq = int'(wr_q); rq = int'(rd_q);
    tot = 0;
    for (int q = 0; q < NQ; q++) tot += m_blk[q];
    acc = cfg_we && (tot - m_blk[cfg_q] + int'(cfg_blks) <= PB);
    hit = prst && (wq == rq);
    if (acc) begin
      m_blk[cfg_q] = int'(cfg_blks); m_cap[cfg_q] = int'(cfg_blks) * BLKW;
      m_af[cfg_q] = int'(cfg_af); m_ae[cfg_q] = int'(cfg_ae);
      for (int q = 0; q < NQ; q++) begin m_cnt[q] = 0; m_hd[q] = 0; m_pk[q] = 0; end
    end else if (hit) begin
      m_cnt[rq] = 0; m_hd[rq] = 0; m_pk[rq] = 0;
    end else begin
      rok = rd_en && m_cnt[rq] > 0;
      wok = wr_en && m_cnt[wq] < m_cap[wq];
      w = {wr_sop, wr_eop, wr_data};
      if (rok) begin
        if (m_buf[rq][m_hd[rq]][DW]) m_pk[rq]--;
        m_hd[rq] = (m_hd[rq] + 1) % MB; m_cnt[rq]--;
      end
      if (wok) begin
        m_buf[wq][(m_hd[wq] + m_cnt[wq]) % MB] = w;
        m_cnt[wq]++;
        if (wr_eop) m_pk[wq]++;
      end
    end
  endtask

  // One cycle: inputs already set by caller at negedge; compare, then edge.
  task automatic cycle();
    #1 compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
    cfg_we = 0; prst = 0;
  endtask

  task automatic rand_cycles(int n, int wp, int rp, int qspan);
    for (int i = 0; i < n; i++) begin
      wr_en = ($urandom % 10) < wp; rd_en = ($urandom % 10) < rp;
      wr_q = QW'($urandom % qspan); rd_q = QW'($urandom % qspan);
      wr_data = {$urandom, $urandom};
      wr_sop = $urandom % 4 == 0; wr_eop = $urandom % 5 == 0;
      prst = $urandom % 300 == 0;
      cycle();
    end
  endtask

  task automatic do_cfg(int q, int b, int af, int ae);
    wr_en = 0; rd_en = 0;
    cfg_we = 1; cfg_q = QW'(q); cfg_blks = BW'(b); cfg_af = CW'(af); cfg_ae = CW'(ae);
    cycle();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    chk(pae_vec == '1, "R1 pae after reset", pae_vec, 16'hffff);
    chk(paf_vec == '0, "R1 paf after reset", paf_vec, 0);
    chk(prdy_vec == '0, "R1 prdy after reset", prdy_vec, 0);
    for (int q = 0; q < NQ; q++) begin
      wr_q = QW'(q); rd_q = QW'(q); #1;
      chk(!wr_full && !rd_valid, "R1 empty queue", {wr_full, rd_valid}, 0);
    end

    // R3: same-queue and cross-queue simultaneous traffic
    wr_q = 3; rd_q = 3; wr_en = 1; wr_data = 36'h111; wr_eop = 0; wr_sop = 1; cycle();
    wr_data = 36'h222; rd_en = 1; cycle();
    wr_en = 0; rd_en = 0; #1;
    chk(rd_valid && rd_data == 36'h222, "R3 same-queue write+read", rd_data, 36'h222);
    wr_q = 4; wr_en = 1; rd_en = 1; wr_data = 36'h333; cycle();
    wr_en = 0; rd_en = 0; rd_q = 4; #1;
    chk(rd_valid && rd_data == 36'h333, "R3 cross-queue write", rd_data, 36'h333);
    rd_q = 3; #1;
    chk(!rd_valid, "R3 cross-queue read drained q3", rd_valid, 0);

    // R2/R4/R7/R8 random fill, drain, mix
    rand_cycles(1500, 9, 2, 3);
    rand_cycles(1500, 2, 9, 3);
    rand_cycles(2000, 5, 5, 16);

    // R6: mismatched partial reset is ignored, matched one empties
    wr_en = 1; rd_en = 0; wr_q = 5; rd_q = 5; wr_eop = 1; wr_data = 36'h5a5;
    cycle(); cycle();
    wr_en = 0; wr_q = 6; prst = 1; cycle();
    #1 chk(rd_valid, "R6 mismatched prst ignored", rd_valid, 1);
    wr_q = 5; prst = 1; wr_en = 1; cycle();
    wr_en = 0; #1;
    chk(!rd_valid && !prdy_vec[5], "R6 matched prst empties", rd_valid, 0);

    // R9/R10: reconfiguration
    do_cfg(1, 0, 8, 4);
    do_cfg(0, 2, 10, 3);
    wr_q = 1; rd_q = 1; #1;
    chk(wr_full && !rd_valid, "R10 zero-block queue", {wr_full, rd_valid}, 2'b10);
    wr_q = 0; rd_q = 0; wr_en = 1; wr_eop = 0;
    for (int i = 0; i < 130; i++) begin wr_data = DW'(i); cycle(); end
    wr_en = 0; #1;
    chk(wr_full, "R4 capacity 128 after cfg", wr_full, 1);
    do_cfg(2, 2, 8, 4);
    rd_q = 0; #1;
    chk(rd_valid && rd_data == 0, "R9 rejected cfg changes nothing", rd_data, 0);
    rd_en = 1;
    for (int i = 0; i < 130; i++) cycle();
    rd_en = 0;
    do_cfg(0, 1, 8, 4);
    do_cfg(1, 1, 8, 4);
    rand_cycles(1500, 6, 5, 16);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule